// File: doc/BRIEF.md
# Multi-Mode Reloadable 8-bit Down-Counter Timer

This block is an 8-bit down-counter with a reload latch. A 4-bit control register picks one of four ways of feeding the counter. It can count a divided internal clock, toggle an external pin, count edges on an external pin, or measure how long that pin stays at a chosen level. Each time the counter passes zero it reloads from the latch. The division ratio is therefore 1/(n+1) for a latch value n, and every such pass raises a sticky underflow request flag.

Software reaches the block through a small register port with a one-cycle write strobe and a combinational read mux. Address 0 writes the reload latch and reads the live count. Address 1 is the control register. Address 2 is the request flag: reading gives the flag in bit 0, and writing 0 to bit 0 clears it. Address 3 reads as zero.

The external pin goes through a two-flop synchronizer before any edge or level is used. A single edge-select bit in the control register changes its meaning with the mode: it picks the counted edge, the measured level, the starting output level and the edge that raises the pin event pulse.

Top module: `mode_timer8`

## Requirements
- R1: Control register (address 1): bits [1:0] select the mode (00 divided-clock, 01 toggle output, 10 edge count, 11 level width), bit 2 is edge-select, bit 3 is stop. Bits [7:4] are not stored and always read 0.
- R2: After synchronous active-low reset, the count and the latch are 0xFF, the control register is 0, the request flag is 0, the pin output is high and the output enable is low.
- R3: Each count pulse decrements a nonzero count by one. A count pulse at 0x00 reloads the count from the latch and is an underflow.
- R4: Each underflow sets the request flag. Writing 0 to bit 0 of address 2 clears it; writing 1 has no effect. An underflow in the same cycle as a clear leaves the flag set.
- R5: In divided-clock mode, one count pulse occurs for every 16 cycles in which `sys_ce` is high. This comes from a free-running prescaler that is cleared by reset.
- R6: The output enable is high only in toggle mode. Every control write sets the pin output to the inverse of written bit 2. In toggle mode, each underflow inverts the output.
- R7: In edge-count mode, one count pulse occurs for each synchronized rising edge of the pin when edge-select is 0, and for each falling edge when it is 1.
- R8: In level-width mode, the prescaler pulses are counted only while the synchronized pin is high (edge-select 0) or low (edge-select 1).
- R9: While the stop bit is 1, no count pulse occurs in any mode and the count changes only through a latch write.
- R10: A latch write while stopped loads both the latch and the count. A latch write while running changes only the latch; the new value is used at the next reload.
- R11: `cntr_evt` pulses for one cycle on a synchronized falling pin edge when edge-select is 0, and on a rising edge when it is 1.
- R12: The pin passes through two flops and edges are detected between the second flop and one further stage. A pin change is therefore counted or flagged no sooner than two clock edges later, and each change yields at most one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_ce | input | 1 | System clock enable feeding the divide-by-16 prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 latch, 1 control, 2 request flag |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 count, 1 control, 2 flag, 3 zero |
| rd_data | output | 8 | Read data (combinational) |
| cntr_in | input | 1 | Asynchronous external pin input |
| cntr_out | output | 1 | Pin output level |
| cntr_oe | output | 1 | Pin output enable (toggle mode) |
| cntr_evt | output | 1 | One-cycle pin edge event |
| uf_irq | output | 1 | Sticky underflow request flag |

## Verification
The hardest case to reach from the ports is an underflow in exactly the same cycle as a software clear of the flag. The bench sets the latch to 0 with `sys_ce` held high, so an underflow occurs every 16 cycles, and then writes a clear on every cycle for several periods. This makes the collision certain. The edge and level modes are driven with a randomly toggling pin. A behavioural model that keeps the recent pin samples in a queue predicts the count, the flag, the output and the event pulse, and every one of them is compared on every clock.

// File: rtl/mtmr_pkg.sv
// Shared definitions for the multi-mode timer: mode encoding, register
// addresses and control-register layout. Assumes a 2-bit register address.
package mtmr_pkg;
    typedef enum logic [1:0] {
        MD_DIVCLK = 2'b00,
        MD_TOGGLE = 2'b01,
        MD_EDGES  = 2'b10,
        MD_WIDTH  = 2'b11
    } mtmr_mode_e;

    localparam logic [1:0] ADDR_COUNT = 2'd0;
    localparam logic [1:0] ADDR_CTRL  = 2'd1;
    localparam logic [1:0] ADDR_FLAG  = 2'd2;

    localparam int CTRL_BITS = 4;
    localparam int CTRL_ES   = 2;
    localparam int CTRL_STOP = 3;
endpackage

// File: rtl/mtmr_pin_sync.sv
// Synchronizes an asynchronous pin through STAGES flops and detects edges
// between the last synchronizer flop and one extra history flop.
// Assumes the pin may change at any time; all flops clear to 0 on reset.
module mtmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_q;

    // Shift the pin through the synchronizer and history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[DEPTH-2:0], pin};
    end

    // Derive level and one-cycle edge strobes from the synchronized samples.
    always_comb begin
        lvl  = sh_q[STAGES-1];
        rise = sh_q[STAGES-1] & ~sh_q[STAGES];
        fall = ~sh_q[STAGES-1] & sh_q[STAGES];
    end
endmodule

// File: rtl/mtmr_prescaler.sv
// Free-running prescaler: emits a one-cycle tick on every DIV-th enabled
// cycle. Assumes DIV >= 2; cleared synchronously by reset.
module mtmr_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    output logic tick
);
    localparam int W = $clog2(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] pre_q;

    // Advance the prescale count on each enabled cycle, wrapping at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)  pre_q <= '0;
        else if (ce) pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
    end

    // Tick on the enabled cycle that wraps the prescaler.
    always_comb tick = ce && (pre_q == LAST);
endmodule

// File: rtl/mtmr_src_sel.sv
// Chooses the count pulse source from the mode and edge-select bit, and
// gates it with the stop bit. Purely combinational.
module mtmr_src_sel
    import mtmr_pkg::*;
(
    input  mtmr_mode_e mode,
    input  logic       edge_sel,
    input  logic       halted,
    input  logic       tick,
    input  logic       lvl,
    input  logic       rise,
    input  logic       fall,
    output logic       pulse
);
    // Select the count pulse for the active mode.
    always_comb begin
        unique case (mode)
            MD_DIVCLK: pulse = tick;
            MD_TOGGLE: pulse = tick;
            MD_EDGES:  pulse = edge_sel ? fall : rise;
            MD_WIDTH:  pulse = tick && (lvl != edge_sel);
            default:   pulse = 1'b0;
        endcase
        if (halted) pulse = 1'b0;
    end
endmodule

// File: rtl/mtmr_reload_cnt.sv
// Down-counter with reload latch. A pulse at zero reloads and flags an
// underflow. A latch write while halted also loads the count. Assumes
// pulse is already low when halted.
module mtmr_reload_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pulse,
    input  logic         halted,
    input  logic         ld_en,
    input  logic [W-1:0] ld_data,
    output logic [W-1:0] count,
    output logic         uf
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lat_q;

    // Hold the reload value written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     lat_q <= '1;
        else if (ld_en) lat_q <= ld_data;
    end

    // Load, reload or decrement the count.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '1;
        else if (ld_en && halted)  cnt_q <= ld_data;
        else if (pulse)            cnt_q <= (cnt_q == '0) ? lat_q : cnt_q - 1'b1;
    end

    // Expose the count and the underflow strobe.
    always_comb begin
        count = cnt_q;
        uf    = pulse && (cnt_q == '0);
    end
endmodule

// File: rtl/mode_timer8.sv
// Top of the multi-mode reloadable timer. Holds the control register,
// request flag and pin output, and joins the synchronizer, prescaler,
// source select and counter. Assumes single-cycle write strobes.
module mode_timer8
    import mtmr_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int PRE_DIV  = 16,
    parameter int SYNC_FFS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_ce,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic             cntr_in,
    output logic             cntr_out,
    output logic             cntr_oe,
    output logic             cntr_evt,
    output logic             uf_irq
);
    logic [CTRL_BITS-1:0] ctrl_q;
    logic                 flag_q;
    logic                 out_q;
    logic                 lvl, rise, fall, tick, pulse, uf;
    logic [WIDTH-1:0]     count;
    logic                 wr_lat, wr_ctrl, wr_flag;
    mtmr_mode_e           mode;
    logic                 edge_sel, halted;

    // Decode register writes and control fields.
    always_comb begin
        wr_lat   = wr_en && (wr_addr == ADDR_COUNT);
        wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
        wr_flag  = wr_en && (wr_addr == ADDR_FLAG);
        mode     = mtmr_mode_e'(ctrl_q[1:0]);
        edge_sel = ctrl_q[CTRL_ES];
        halted   = ctrl_q[CTRL_STOP];
    end

    mtmr_pin_sync #(.STAGES(SYNC_FFS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(cntr_in),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    mtmr_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .ce(sys_ce), .tick(tick)
    );

    mtmr_src_sel u_sel (
        .mode(mode), .edge_sel(edge_sel), .halted(halted), .tick(tick),
        .lvl(lvl), .rise(rise), .fall(fall), .pulse(pulse)
    );

    mtmr_reload_cnt #(.W(WIDTH)) u_cnt (
        .clk(clk), .rst_n(rst_n), .pulse(pulse), .halted(halted),
        .ld_en(wr_lat), .ld_data(wr_data), .count(count), .uf(uf)
    );

    // Store the 4 implemented control bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wr_data[CTRL_BITS-1:0];
    end

    // Sticky request flag: underflow sets, a write of 0 clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                      flag_q <= 1'b0;
        else if (uf)                     flag_q <= 1'b1;
        else if (wr_flag && !wr_data[0]) flag_q <= 1'b0;
    end

    // Pin output: preset from edge-select on control writes, toggle on underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)                        out_q <= 1'b1;
        else if (wr_ctrl)                  out_q <= ~wr_data[CTRL_ES];
        else if (mode == MD_TOGGLE && uf)  out_q <= ~out_q;
    end

    // Drive outputs and the read mux.
    always_comb begin
        cntr_out = out_q;
        cntr_oe  = (mode == MD_TOGGLE);
        cntr_evt = edge_sel ? rise : fall;
        uf_irq   = flag_q;
        unique case (rd_addr)
            ADDR_COUNT: rd_data = count;
            ADDR_CTRL:  rd_data = WIDTH'(ctrl_q);
            ADDR_FLAG:  rd_data = WIDTH'(flag_q);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mode_timer8_chk.sv
// Assertion checker for mode_timer8, attached by bind.
module mode_timer8_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [WIDTH-1:0] wr_data,
    input logic [1:0]       rd_addr,
    input logic [WIDTH-1:0] rd_data,
    input logic             cntr_out,
    input logic             uf_irq,
    input logic [WIDTH-1:0] count,
    input logic             pulse,
    input logic             uf,
    input logic             halted
);
    // R1
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 2'd1) |-> (rd_data[WIDTH-1:4] == '0));

    // R3
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && count != '0) |=> (count == $past(count) - 1'b1));

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> uf_irq);

    // R6
    out_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |=> (cntr_out == !$past(wr_data[2])));

    // R9
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !(wr_en && wr_addr == 2'd0)) |=> $stable(count));

    // R10
    running_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !pulse && wr_en && wr_addr == 2'd0) |=> $stable(count));
endmodule

bind mode_timer8 mode_timer8_chk #(.WIDTH(WIDTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cntr_out(cntr_out), .uf_irq(uf_irq), .count(count),
    .pulse(pulse), .uf(uf), .halted(halted)
);

// File: tb/mode_timer8_tb_top.sv
module mode_timer8_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_ce = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       cntr_in = 1'b0;
    logic       cntr_out, cntr_oe, cntr_evt, uf_irq;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cyc = 0;
    bit    done = 0;
    bit    cmp_on = 0;
    string tag = "R3 R5";
    int    pin_rate = 0;
    int    ce_rate = 100;

    // reference model state
    int   m_pre = 0;
    logic [7:0] m_cnt = 8'hFF, m_lat = 8'hFF, m_mode = 8'h00;
    bit   m_irq = 0, m_out = 1;
    bit   hist[$] = '{0, 0, 0};  // [0] newest sample, [1] synced level, [2] previous level

    mode_timer8 dut_i (
        .clk(clk), .rst_n(rst_n), .sys_ce(sys_ce), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .cntr_in(cntr_in), .cntr_out(cntr_out),
        .cntr_oe(cntr_oe), .cntr_evt(cntr_evt), .uf_irq(uf_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    // Behavioural reference, advanced on every clock edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_pre = 0; m_cnt = 8'hFF; m_lat = 8'hFF; m_mode = 0;
            m_irq = 0; m_out = 1; hist = '{0, 0, 0};
        end else begin
            bit tk, p, uf, es, rs, fl;
            logic [7:0] nxt;
            tk = sys_ce && (m_pre == 15);
            es = m_mode[2];
            rs = hist[1] && !hist[2];
            fl = !hist[1] && hist[2];
            case (m_mode[1:0])
                2'd0, 2'd1: p = tk;
                2'd2:       p = es ? fl : rs;
                default:    p = tk && (hist[1] != es);
            endcase
            if (m_mode[3]) p = 0;
            uf = p && (m_cnt == 0);
            nxt = m_cnt;
            if (wr_en && wr_addr == 0 && m_mode[3]) nxt = wr_data;
            else if (p) nxt = (m_cnt == 0) ? m_lat : m_cnt - 8'd1;
            if (wr_en && wr_addr == 0) m_lat = wr_data;
            m_cnt = nxt;
            if (uf) m_irq = 1;
            else if (wr_en && wr_addr == 2 && !wr_data[0]) m_irq = 0;
            if (wr_en && wr_addr == 1) m_out = !wr_data[2];
            else if (m_mode[1:0] == 2'd1 && uf) m_out = !m_out;
            if (wr_en && wr_addr == 1) m_mode = {4'b0, wr_data[3:0]};
            if (sys_ce) m_pre = (m_pre + 1) % 16;
            hist.push_front(cntr_in);
            void'(hist.pop_back());
        end
        if (cyc > WATCHDOG && !done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            logic [7:0] exp_rd;
            bit ev;
            case (rd_addr)
                2'd0: exp_rd = m_cnt;
                2'd1: exp_rd = m_mode;
                2'd2: exp_rd = {7'b0, m_irq};
                default: exp_rd = 8'h00;
            endcase
            ev = m_mode[2] ? (hist[1] && !hist[2]) : (!hist[1] && hist[2]);
            check((rd_addr == 1) ? "R1 read" : {tag, " read"}, rd_data, exp_rd);
            check("R4 flag", {7'b0, uf_irq}, {7'b0, m_irq});
            check("R6 out", {7'b0, cntr_out}, {7'b0, m_out});
            check("R6 oe", {7'b0, cntr_oe}, {7'b0, m_mode[1:0] == 2'd1});
            check("R11 R12 evt", {7'b0, cntr_evt}, {7'b0, ev});
        end
    end

    // One cycle of stimulus, driven just after the falling edge.
    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            wr_en   = 0;
            rd_addr = 2'($urandom_range(0, 3));
            if (pin_rate > 0 && $urandom_range(0, 99) < pin_rate) cntr_in = !cntr_in;
            sys_ce  = ($urandom_range(0, 99) < ce_rate);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d;
        rd_addr = 2'($urandom_range(0, 3));
    endtask

    initial begin
        rst_n = 0;
        cntr_in = 1;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R2: reset state, before any stimulus
        rd_addr = 0; #1;
        check("R2 count", rd_data, 8'hFF);
        rd_addr = 1; #1;
        check("R2 ctrl", rd_data, 8'h00);
        check("R2 flag", {7'b0, uf_irq}, 8'h00);
        check("R2 out", {7'b0, cntr_out}, 8'h01);
        check("R2 oe", {7'b0, cntr_oe}, 8'h00);
        cmp_on = 1;

        // R5 R3: divided-clock mode, latch loaded while stopped
        tag = "R10 R5";
        wr(1, 8'h08); wr(0, 8'h03); wr(1, 8'h00);
        tag = "R3 R5";
        step(300);
        ce_rate = 70; step(300); ce_rate = 100;

        // R4: clear on every cycle with latch 0, forcing set/clear collisions
        wr(1, 8'h08); wr(0, 8'h00); wr(1, 8'h00);
        tag = "R4";
        for (int i = 0; i < 64; i++) wr(2, 8'h00);
        wr(2, 8'h01); step(5);

        // R10: latch write while running takes effect at reload
        tag = "R10";
        wr(0, 8'h05); step(200);

        // R1: upper control bits discarded
        tag = "R1";
        wr(1, 8'hF8); step(4);

        // R6: toggle mode, both starting levels
        tag = "R6";
        wr(0, 8'h02); wr(1, 8'h01); step(300);
        wr(1, 8'h05); step(300);

        // R7 R12: edge-count mode, both edges, with a random pin
        pin_rate = 30;
        tag = "R7 R12";
        wr(0, 8'h04); wr(1, 8'h02); step(400);
        wr(1, 8'h06); step(400);

        // R8: level-width mode, both levels
        tag = "R8";
        pin_rate = 5;
        wr(1, 8'h03); step(500);
        wr(1, 8'h07); step(500);

        // R9: stop in every mode while the pin and prescaler keep moving
        tag = "R9";
        pin_rate = 30;
        for (int m = 0; m < 4; m++) begin
            wr(1, 8'(8 + m)); step(80);
            wr(0, 8'(8'h40 + m)); step(20);
        end
        wr(1, 8'h02); step(100);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule